// File: doc/BRIEF.md
# Fused-Operation 64-bit Integer ALU

This block is the integer execution unit of a 64-bit processor core. One operation code, two 64-bit operands and a valid strobe go in, and one cycle later a 64-bit result leaves from a register with a matching valid flag. All computation is combinational, between the input ports and that output register.

Besides the usual arithmetic, logic, shift and compare work, the unit handles several operation families:
- 32-bit word operations whose results are sign-extended to 64 bits;
- single-bit and rotate/reverse/pack bit manipulation;
- scaled address adds;
- fused idioms, each of which merges an add or a logic operation with the extract or extend that would otherwise follow it.

Bits [6:4] of the operation code select an operation family. Any code that is not defined yields zero.

Top module: `alu_fused_top`

## Requirements
- R1: On a rising edge with `rst` high, `out_valid` and `out_result` become 0. Otherwise `out_valid` takes `in_valid` one edge later. `out_result` loads the computed value only on edges where `in_valid` is 1, and holds its value on all other edges.
- R2: Every undefined code gives a result of 0. The undefined codes are:
  - group 0x70-0x7F;
  - 0x08, 0x0A, 0x0C-0x0F, 0x1B, 0x1E, 0x1F, 0x2E, 0x33, 0x38-0x3F;
  - 0x47, 0x4C-0x4F, 0x53-0x5F, 0x68-0x6F.
- R3: 64-bit shifts and rotates take the amount k from b[5:0]:
  - 0x01: a<<k;
  - 0x05: logical a>>k;
  - 0x07: arithmetic a>>k;
  - 0x09: rotate left;
  - 0x0B: rotate right;
  - 0x00: zero-extended a[31:0] shifted left by k.
- R4: The single-bit operations use idx=b[5:0]:
  - 0x02: a & ~(1<<idx);
  - 0x03: a | (1<<idx);
  - 0x04: a ^ (1<<idx);
  - 0x06: bit idx of a, returned in bit 0 with all other bits zero.
- R5: Word operations work on 32 bits, take shift amounts from b[4:0], and sign-extend bit 31 of their result:
  - 0x10: add;
  - 0x12: subtract;
  - 0x18: shift left;
  - 0x19: logical shift right of a[31:0];
  - 0x1A: arithmetic shift right of a[31:0];
  - 0x1C: rotate left;
  - 0x1D: rotate right.
- R6: The subtract and compare group:
  - 0x30: a-b;
  - 0x31: unsigned a<b, returned as 0 or 1;
  - 0x32: signed a<b, returned as 0 or 1;
  - 0x34 / 0x35: unsigned max / min;
  - 0x36 / 0x37: signed max / min.
- R7: Scaled adds compute (x<<s)+b.
  - With x=a: s=1 at 0x29, s=2 at 0x2B, s=3 at 0x2D, s=4 at 0x2F.
  - With x=zero-extended a[31:0]: s=1 at 0x28, s=2 at 0x2A, s=3 at 0x2C.
  - 0x21 is a+b, and 0x20 is zero-extended a[31:0] plus b.
- R8: Codes 0x24, 0x25, 0x26 and 0x27 compute (a>>N)+b, with N = 29, 30, 31 and 32 respectively.
- R9: Code 0x22 computes a[0]+b, and 0x11 is the same sum with its low 32 bits sign-extended. Code 0x23 computes sext(b[11:0]) + (b with bits [11:0] cleared), and 0x13 is the same sum with its low 32 bits sign-extended.
- R10: Fused adds on the 64-bit sum a+b:
  - 0x14: bit 0 of the sum;
  - 0x15: the zero-extended low byte;
  - 0x16: the zero-extended low halfword;
  - 0x17: the sign-extended low halfword.
- R11: Logic and extend operations:
  - 0x40 a&b, 0x41 a&~b, 0x42 a|b, 0x43 a|~b, 0x44 a^b, 0x45 ~(a^b);
  - 0x46: each byte of a becomes 0xFF if it is nonzero, else 0x00;
  - 0x48: a[7:0] sign-extended;
  - 0x49: zero-extended {b[7:0],a[7:0]};
  - 0x4A: a[15:0] sign-extended;
  - 0x4B: {b[15:0],a[15:0]} sign-extended from bit 31;
  - 0x50: the bits of each byte of a reversed;
  - 0x51: the byte order of a reversed;
  - 0x52: {b[31:0],a[31:0]}.
- R12: Fused logic codes have the form {3'b110, 1'b0, f[1:0], sel}. The base result is chosen by f: 0 gives a&b, 1 gives a|b, 2 gives a^b, 3 gives the byte-wise nonzero mask of a. sel=0 keeps only bit 0 of the base result; sel=1 keeps the zero-extended bits [15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation valid this cycle |
| in_op | input | 7 | Operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Registered result valid |
| out_result | output | 64 | Registered result |

## Verification
On every cycle, the checker enforces:
- the valid timing and result hold;
- the reset values;
- zero results for the unused top group;
- the sign-extension shape of word results;
- the zero upper bits of compare, bit-extract, fused-add and fused-logic results.

It only constrains shape, though, not values. The actual arithmetic values are shown only by the bench's scenarios. These run every defined code and a set of undefined codes over corner and random operand pairs, and compare each result against an independently written model. That includes rotate by zero, word shifts of 31, the signed/unsigned boundaries, and carries that cross bit 31.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;
  localparam int OP_W   = 7;
  localparam int HI_BASE = 29;

  localparam logic [2:0] GRP_SHIFT = 3'b000;
  localparam logic [2:0] GRP_WORD  = 3'b001;
  localparam logic [2:0] GRP_ADD   = 3'b010;
  localparam logic [2:0] GRP_SUB   = 3'b011;
  localparam logic [2:0] GRP_LOGA  = 3'b100;
  localparam logic [2:0] GRP_LOGB  = 3'b101;
  localparam logic [2:0] GRP_FLOG  = 3'b110;

  localparam logic [OP_W-1:0] OP_SHLZW   = 7'h00, OP_SHL     = 7'h01, OP_BITCLR  = 7'h02;
  localparam logic [OP_W-1:0] OP_BITSET  = 7'h03, OP_BITFLIP = 7'h04, OP_SHR     = 7'h05;
  localparam logic [OP_W-1:0] OP_BITGET  = 7'h06, OP_SAR     = 7'h07, OP_ROTL    = 7'h09;
  localparam logic [OP_W-1:0] OP_ROTR    = 7'h0B;
  localparam logic [OP_W-1:0] OP_ADD32   = 7'h10, OP_LSBADD32 = 7'h11, OP_SUB32  = 7'h12;
  localparam logic [OP_W-1:0] OP_IMMADD32 = 7'h13, OP_ADDBIT  = 7'h14, OP_ADDBYTE = 7'h15;
  localparam logic [OP_W-1:0] OP_ADDZH   = 7'h16, OP_ADDSH    = 7'h17, OP_SHL32  = 7'h18;
  localparam logic [OP_W-1:0] OP_SHR32   = 7'h19, OP_SAR32    = 7'h1A, OP_ROTL32 = 7'h1C;
  localparam logic [OP_W-1:0] OP_ROTR32  = 7'h1D;
  localparam logic [OP_W-1:0] OP_ADDZW   = 7'h20, OP_ADD      = 7'h21, OP_LSBADD = 7'h22;
  localparam logic [OP_W-1:0] OP_IMMADD  = 7'h23, OP_HI29ADD  = 7'h24, OP_HI32ADD = 7'h27;
  localparam logic [OP_W-1:0] OP_SC1ADDZW = 7'h28, OP_SC4ADD  = 7'h2F, OP_SCGAP  = 7'h2E;
  localparam logic [OP_W-1:0] OP_SUB     = 7'h30, OP_LTU      = 7'h31, OP_LT     = 7'h32;
  localparam logic [OP_W-1:0] OP_MAXU    = 7'h34, OP_MINU     = 7'h35, OP_MAX    = 7'h36;
  localparam logic [OP_W-1:0] OP_MIN     = 7'h37;
  localparam logic [OP_W-1:0] OP_AND     = 7'h40, OP_ANDN     = 7'h41, OP_OR     = 7'h42;
  localparam logic [OP_W-1:0] OP_ORN     = 7'h43, OP_XOR      = 7'h44, OP_XNOR   = 7'h45;
  localparam logic [OP_W-1:0] OP_ORBYTE  = 7'h46, OP_SXB      = 7'h48, OP_PACKLO8 = 7'h49;
  localparam logic [OP_W-1:0] OP_SXH     = 7'h4A, OP_PACK16W  = 7'h4B, OP_BITREVB = 7'h50;
  localparam logic [OP_W-1:0] OP_BYTEREV = 7'h51, OP_PACK32   = 7'h52;

  function automatic logic [DATA_W-1:0] sx_word(input logic [WORD_W-1:0] v);
    return {{(DATA_W-WORD_W){v[WORD_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] zx_word(input logic [WORD_W-1:0] v);
    return {{(DATA_W-WORD_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int WSH_W = $clog2(WORD_W);

  logic [SH_W-1:0]     amt;
  logic [WSH_W-1:0]    wamt;
  logic [DATA_W-1:0]   onehot, sra_v;
  logic [2*DATA_W-1:0] dbl_l, dbl_r;
  logic [WORD_W-1:0]   aw, wshl, wshr, wsra;
  logic [2*WORD_W-1:0] wdbl_l, wdbl_r;

  assign amt    = b[SH_W-1:0];
  assign wamt   = b[WSH_W-1:0];
  assign aw     = a[WORD_W-1:0];
  assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << amt;
  assign sra_v  = $signed(a) >>> amt;
  assign dbl_l  = {a, a} << amt;
  assign dbl_r  = {a, a} >> amt;
  assign wshl   = aw << wamt;
  assign wshr   = aw >> wamt;
  assign wsra   = $signed(aw) >>> wamt;
  assign wdbl_l = {aw, aw} << wamt;
  assign wdbl_r = {aw, aw} >> wamt;

  always_comb begin
    case (op)
      OP_SHLZW:   res = zx_word(aw) << amt;
      OP_SHL:     res = a << amt;
      OP_BITCLR:  res = a & ~onehot;
      OP_BITSET:  res = a | onehot;
      OP_BITFLIP: res = a ^ onehot;
      OP_SHR:     res = a >> amt;
      OP_BITGET:  res = {{(DATA_W-1){1'b0}}, |(a & onehot)};
      OP_SAR:     res = sra_v;
      OP_ROTL:    res = dbl_l[2*DATA_W-1:DATA_W];
      OP_ROTR:    res = dbl_r[DATA_W-1:0];
      OP_SHL32:   res = sx_word(wshl);
      OP_SHR32:   res = sx_word(wshr);
      OP_SAR32:   res = sx_word(wsra);
      OP_ROTL32:  res = sx_word(wdbl_l[2*WORD_W-1:WORD_W]);
      OP_ROTR32:  res = sx_word(wdbl_r[WORD_W-1:0]);
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/alu_add_unit.sv
module alu_add_unit
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int IMM_W = 12;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] lhs, rhs, sum, diff, base;
  logic lt_u, lt_s, is_imm;

  assign is_imm = (op == OP_IMMADD) || (op == OP_IMMADD32);
  assign base   = op[0] ? a : zx_word(a[WORD_W-1:0]);

  always_comb begin
    lhs = a;
    if (op == OP_LSBADD || op == OP_LSBADD32)
      lhs = {{(DATA_W-1){1'b0}}, a[0]};
    else if (is_imm)
      lhs = {{(DATA_W-IMM_W){b[IMM_W-1]}}, b[IMM_W-1:0]};
    else if (op == OP_ADDZW)
      lhs = zx_word(a[WORD_W-1:0]);
    else if (op >= OP_HI29ADD && op <= OP_HI32ADD)
      lhs = a >> (HI_BASE + int'(op[1:0]));
    else if (op >= OP_SC1ADDZW && op <= OP_SC4ADD)
      lhs = base << (int'(op[2:1]) + 1);
  end

  assign rhs  = is_imm ? {b[DATA_W-1:IMM_W], {IMM_W{1'b0}}} : b;
  assign sum  = lhs + rhs;
  assign diff = a - b;
  assign lt_u = a < b;
  assign lt_s = $signed(a) < $signed(b);

  always_comb begin
    res = '0;
    case (op)
      OP_ADD32, OP_LSBADD32, OP_IMMADD32: res = sx_word(sum[WORD_W-1:0]);
      OP_SUB32:   res = sx_word(diff[WORD_W-1:0]);
      OP_ADDBIT:  res = {{(DATA_W-1){1'b0}}, sum[0]};
      OP_ADDBYTE: res = {{(DATA_W-BYTE_W){1'b0}}, sum[BYTE_W-1:0]};
      OP_ADDZH:   res = {{(DATA_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
      OP_ADDSH:   res = {{(DATA_W-HALF_W){sum[HALF_W-1]}}, sum[HALF_W-1:0]};
      OP_SUB:     res = diff;
      OP_LTU:     res = {{(DATA_W-1){1'b0}}, lt_u};
      OP_LT:      res = {{(DATA_W-1){1'b0}}, lt_s};
      OP_MAXU:    res = lt_u ? b : a;
      OP_MINU:    res = lt_u ? a : b;
      OP_MAX:     res = lt_s ? b : a;
      OP_MIN:     res = lt_s ? a : b;
      default:
        if (op[OP_W-1:4] == GRP_ADD && op != OP_SCGAP) res = sum;
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  localparam int NBYTES = DATA_W / 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] nzmask, bitrev, byterev, fbase;

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      nzmask[i*8 +: 8]  = {8{|a[i*8 +: 8]}};
      byterev[i*8 +: 8] = a[(NBYTES-1-i)*8 +: 8];
      for (int j = 0; j < 8; j++) bitrev[i*8 + j] = a[i*8 + 7 - j];
    end
  end

  always_comb begin
    case (op[2:1])
      2'd0:    fbase = a & b;
      2'd1:    fbase = a | b;
      2'd2:    fbase = a ^ b;
      default: fbase = nzmask;
    endcase
  end

  always_comb begin
    case (op)
      OP_AND:     res = a & b;
      OP_ANDN:    res = a & ~b;
      OP_OR:      res = a | b;
      OP_ORN:     res = a | ~b;
      OP_XOR:     res = a ^ b;
      OP_XNOR:    res = ~(a ^ b);
      OP_ORBYTE:  res = nzmask;
      OP_SXB:     res = {{(DATA_W-8){a[7]}}, a[7:0]};
      OP_PACKLO8: res = {{(DATA_W-16){1'b0}}, b[7:0], a[7:0]};
      OP_SXH:     res = {{(DATA_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
      OP_PACK16W: res = sx_word({b[15:0], a[15:0]});
      OP_BITREVB: res = bitrev;
      OP_BYTEREV: res = byterev;
      OP_PACK32:  res = {b[WORD_W-1:0], a[WORD_W-1:0]};
      default:
        if (op[OP_W-1:3] == {GRP_FLOG, 1'b0})
          res = op[0] ? {{(DATA_W-HALF_W){1'b0}}, fbase[HALF_W-1:0]}
                      : {{(DATA_W-1){1'b0}}, fbase[0]};
        else
          res = '0;
    endcase
  end
endmodule

// File: rtl/alu_fused_top.sv
module alu_fused_top
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result
);
  logic [DATA_W-1:0] shift_res, add_res, logic_res, sel_res;
  logic [2:0] grp;

  assign grp = in_op[OP_W-1:4];

  alu_shift_unit u_shift (.op(in_op), .a(in_a), .b(in_b), .res(shift_res));
  alu_add_unit   u_add   (.op(in_op), .a(in_a), .b(in_b), .res(add_res));
  alu_logic_unit u_logic (.op(in_op), .a(in_a), .b(in_b), .res(logic_res));

  always_comb begin
    case (grp)
      GRP_SHIFT:                    sel_res = shift_res;
      GRP_WORD:                     sel_res = in_op[3] ? shift_res : add_res;
      GRP_ADD, GRP_SUB:             sel_res = add_res;
      GRP_LOGA, GRP_LOGB, GRP_FLOG: sel_res = logic_res;
      default:                      sel_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= sel_res;
    end
  end
endmodule

// File: rtl/alu_fused_chk.sv
module alu_fused_chk
  import alu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result
);
  logic word_op;
  assign word_op = in_op inside {OP_ADD32, OP_LSBADD32, OP_SUB32, OP_IMMADD32,
                                 OP_SHL32, OP_SHR32, OP_SAR32, OP_ROTL32, OP_ROTR32};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result)));
  p_top_group_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[OP_W-1:4] == 3'b111) |=> out_result == '0);
  p_bitget_shape_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_BITGET) |=> out_result[DATA_W-1:1] == '0);
  p_word_sext_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_op) |=> out_result[DATA_W-1:WORD_W] == {(DATA_W-WORD_W){out_result[WORD_W-1]}});
  p_cmp_shape_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_LTU || in_op == OP_LT)) |=> out_result[DATA_W-1:1] == '0);
  p_addbit_shape_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADDBIT) |=> out_result[DATA_W-1:1] == '0);
  p_addzh_shape_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADDZH) |=> out_result[DATA_W-1:16] == '0);
  p_flog_bit_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[OP_W-1:3] == 4'b1100 && !in_op[0]) |=> out_result[DATA_W-1:1] == '0);
  p_flog_half_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[OP_W-1:3] == 4'b1100 && in_op[0]) |=> out_result[DATA_W-1:16] == '0);
endmodule

bind alu_fused_top alu_fused_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/tb_alu_fused_top.sv
module tb_alu_fused_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  alu_fused_top dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish (got %0d cycles, expected < 150000)", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] nz_bytes(input logic [63:0] v);
    logic [63:0] t;
    for (int i = 0; i < 8; i++) t[i*8 +: 8] = (v[i*8 +: 8] != 8'd0) ? 8'hFF : 8'h00;
    return t;
  endfunction

  function automatic logic [63:0] model(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] s, t;
    logic [31:0] w;
    int k;
    k = int'(b[5:0]);
    case (op)
      7'h00: return {32'd0, a[31:0]} << k;
      7'h01: return a << k;
      7'h02: return a & ~(64'd1 << k);
      7'h03: return a | (64'd1 << k);
      7'h04: return a ^ (64'd1 << k);
      7'h05: return a >> k;
      7'h06: return {63'd0, a[k]};
      7'h07: begin s = $signed(a) >>> k; return s; end
      7'h09: return (k == 0) ? a : ((a << k) | (a >> (64 - k)));
      7'h0B: return (k == 0) ? a : ((a >> k) | (a << (64 - k)));
      7'h10: begin w = a[31:0] + b[31:0]; return sx32(w); end
      7'h11: begin s = {63'd0, a[0]} + b; return sx32(s[31:0]); end
      7'h12: begin w = a[31:0] - b[31:0]; return sx32(w); end
      7'h13: begin s = {{52{b[11]}}, b[11:0]} + {b[63:12], 12'd0}; return sx32(s[31:0]); end
      7'h14: begin s = a + b; return {63'd0, s[0]}; end
      7'h15: begin s = a + b; return {56'd0, s[7:0]}; end
      7'h16: begin s = a + b; return {48'd0, s[15:0]}; end
      7'h17: begin s = a + b; return {{48{s[15]}}, s[15:0]}; end
      7'h18: begin w = a[31:0] << b[4:0]; return sx32(w); end
      7'h19: begin w = a[31:0] >> b[4:0]; return sx32(w); end
      7'h1A: begin w = $signed(a[31:0]) >>> b[4:0]; return sx32(w); end
      7'h1C: begin k = int'(b[4:0]);
               w = (k == 0) ? a[31:0] : ((a[31:0] << k) | (a[31:0] >> (32 - k))); return sx32(w); end
      7'h1D: begin k = int'(b[4:0]);
               w = (k == 0) ? a[31:0] : ((a[31:0] >> k) | (a[31:0] << (32 - k))); return sx32(w); end
      7'h20: return {32'd0, a[31:0]} + b;
      7'h21: return a + b;
      7'h22: return {63'd0, a[0]} + b;
      7'h23: return {{52{b[11]}}, b[11:0]} + {b[63:12], 12'd0};
      7'h24: return (a >> 29) + b;
      7'h25: return (a >> 30) + b;
      7'h26: return (a >> 31) + b;
      7'h27: return (a >> 32) + b;
      7'h28: return ({32'd0, a[31:0]} << 1) + b;
      7'h29: return (a << 1) + b;
      7'h2A: return ({32'd0, a[31:0]} << 2) + b;
      7'h2B: return (a << 2) + b;
      7'h2C: return ({32'd0, a[31:0]} << 3) + b;
      7'h2D: return (a << 3) + b;
      7'h2F: return (a << 4) + b;
      7'h30: return a - b;
      7'h31: return {63'd0, a < b};
      7'h32: return {63'd0, $signed(a) < $signed(b)};
      7'h34: return (a > b) ? a : b;
      7'h35: return (a > b) ? b : a;
      7'h36: return ($signed(a) > $signed(b)) ? a : b;
      7'h37: return ($signed(a) > $signed(b)) ? b : a;
      7'h40: return a & b;
      7'h41: return a & ~b;
      7'h42: return a | b;
      7'h43: return a | ~b;
      7'h44: return a ^ b;
      7'h45: return ~(a ^ b);
      7'h46: return nz_bytes(a);
      7'h48: return {{56{a[7]}}, a[7:0]};
      7'h49: return {48'd0, b[7:0], a[7:0]};
      7'h4A: return {{48{a[15]}}, a[15:0]};
      7'h4B: return sx32({b[15:0], a[15:0]});
      7'h50: begin for (int i = 0; i < 64; i++) t[i] = a[(i/8)*8 + 7 - (i%8)]; return t; end
      7'h51: begin for (int i = 0; i < 8; i++) t[i*8 +: 8] = a[(7-i)*8 +: 8]; return t; end
      7'h52: return {b[31:0], a[31:0]};
      7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
        case (op[2:1])
          2'd0: t = a & b;
          2'd1: t = a | b;
          2'd2: t = a ^ b;
          default: t = nz_bytes(a);
        endcase
        return op[0] ? {48'd0, t[15:0]} : {63'd0, t[0]};
      end
      default: return 64'd0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic drive_check(input logic [6:0] op, input logic [63:0] a, input logic [63:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    check(tag, $sformatf("op %h a %h b %h", op, a, b), out_result, model(op, a, b));
  endtask

  task automatic sweep_code(input logic [6:0] op, input string tag);
    logic [63:0] vals [8];
    vals[0] = 64'd0;                  vals[1] = '1;
    vals[2] = 64'h8000_0000_0000_0000; vals[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    vals[4] = 64'h0000_0000_8000_0FFF; vals[5] = 64'h1234_5678_9ABC_DEF0;
    vals[6] = 64'd31;                 vals[7] = 64'hFFFF_FFFF_7FFF_F83F;
    foreach (vals[i]) foreach (vals[j]) drive_check(op, vals[i], vals[j], tag);
    for (int r = 0; r < 6; r++) drive_check(op, {$urandom, $urandom}, {$urandom, $urandom}, tag);
  endtask

  task automatic t_reset_and_hold();
    check("R1", "reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "reset out_result", out_result, 64'd0);
    rst = 1'b0;
    drive_check(7'h21, 64'd5, 64'd7, "R1");
    check("R1", "valid after issue", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0; in_op = 7'h30; in_a = 64'd1; in_b = 64'd100;
    @(negedge clk);
    check("R1", "idle valid", {63'd0, out_valid}, 64'd0);
    check("R1", "idle hold", out_result, 64'd12);
    in_valid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", "reset over valid", out_result, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_undefined();
    logic [6:0] codes [12] = '{7'h08, 7'h0E, 7'h1B, 7'h1F, 7'h2E, 7'h33,
                               7'h3C, 7'h47, 7'h4D, 7'h58, 7'h6A, 7'h75};
    foreach (codes[i]) sweep_code(codes[i], "R2");
  endtask

  task automatic t_shifts();
    logic [6:0] codes [6] = '{7'h00, 7'h01, 7'h05, 7'h07, 7'h09, 7'h0B};
    foreach (codes[i]) sweep_code(codes[i], "R3");
  endtask

  task automatic t_single_bit();
    logic [6:0] codes [4] = '{7'h02, 7'h03, 7'h04, 7'h06};
    foreach (codes[i]) sweep_code(codes[i], "R4");
  endtask

  task automatic t_word();
    logic [6:0] codes [7] = '{7'h10, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D};
    foreach (codes[i]) sweep_code(codes[i], "R5");
  endtask

  task automatic t_compare();
    logic [6:0] codes [7] = '{7'h30, 7'h31, 7'h32, 7'h34, 7'h35, 7'h36, 7'h37};
    foreach (codes[i]) sweep_code(codes[i], "R6");
  endtask

  task automatic t_scaled_add();
    logic [6:0] codes [9] = '{7'h20, 7'h21, 7'h28, 7'h29, 7'h2A, 7'h2B, 7'h2C, 7'h2D, 7'h2F};
    foreach (codes[i]) sweep_code(codes[i], "R7");
  endtask

  task automatic t_high_add();
    for (int c = 'h24; c <= 'h27; c++) sweep_code(7'(c), "R8");
  endtask

  task automatic t_lsb_imm_add();
    logic [6:0] codes [4] = '{7'h22, 7'h11, 7'h23, 7'h13};
    foreach (codes[i]) sweep_code(codes[i], "R9");
    drive_check(7'h23, 64'd0, 64'h0000_0000_0001_2800, "R9");
  endtask

  task automatic t_fused_add();
    for (int c = 'h14; c <= 'h17; c++) sweep_code(7'(c), "R10");
  endtask

  task automatic t_logic();
    logic [6:0] codes [14] = '{7'h40, 7'h41, 7'h42, 7'h43, 7'h44, 7'h45, 7'h46,
                               7'h48, 7'h49, 7'h4A, 7'h4B, 7'h50, 7'h51, 7'h52};
    foreach (codes[i]) sweep_code(codes[i], "R11");
  endtask

  task automatic t_fused_logic();
    for (int c = 'h60; c <= 'h67; c++) sweep_code(7'(c), "R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_hold();
    t_undefined();
    t_shifts();
    t_single_bit();
    t_word();
    t_compare();
    t_scaled_add();
    t_high_add();
    t_lsb_imm_add();
    t_fused_add();
    t_logic();
    t_fused_logic();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule